// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Output Timing and Rewind

This block is a first-in first-out buffer for 9-bit words. It has independent write and read clocks, so a producer and a consumer in unrelated clock domains can exchange data. The number of words it holds is a parameter. Each side keeps a binary pointer and a gray-coded copy of it. The gray copy crosses into the other clock domain through a two-stage synchroniser. The full condition is formed on the write side and the empty condition on the read side.

A strap input is captured while master reset is held, and it selects one of two output disciplines. In standard timing the consumer asks for each word with a read enable, and the two status pins report empty and full. In fall-through timing an output register is loaded automatically whenever storage holds data. The two status pins then report that a valid word is presented and that a write would be accepted. The output register counts as one extra word of capacity.

A partial reset empties the buffer but keeps the captured timing mode. A retransmit pulse moves the read side back to the first word written since the most recent reset, so a block of data can be replayed.

Top module: `dm_fifo`

## Requirements
- R1: While `rst_ni` is low, `fwft_i` is captured as the timing mode (0 = standard, 1 = fall-through). In standard mode `rd_flag_o` is 1 when the buffer is empty and `wr_flag_o` is 1 when it is full. In fall-through mode `rd_flag_o` is 1 when `dout_o` holds a valid word and `wr_flag_o` is 1 when a write will be accepted.
- R2: In standard mode, a read-clock edge with `ren_i` = 1 and the buffer not empty places the oldest stored word on `dout_o`. Words leave in the order they were accepted.
- R3: A write while the buffer reports full is dropped: no pointer moves and no stored word changes. A standard-mode read while the buffer is empty leaves `dout_o` and the read pointer unchanged.
- R4: In fall-through mode, a word written into an empty buffer appears on `dout_o` with `rd_flag_o` = 1 at the third read-clock edge after its write edge, without `ren_i`. It stays there until `ren_i` consumes it.
- R5: With no reads, exactly DEPTH writes are accepted in standard mode and DEPTH+1 in fall-through mode.
- R6: `half_o` is 1 when the write side sees more than DEPTH/2 words in the storage array, and it returns to 0 once reads bring the count back to DEPTH/2 or below.
- R7: Master reset (`rst_ni` low) discards all data and recaptures the mode. Partial reset (`prst_ni` low) discards all data and `dout_o` returns to 0, but the mode captured at the last master reset is kept.
- R8: A read-clock edge with `rt_i` = 1 rewinds the read side. Subsequent reads return the words in order from the first one written after the last master or partial reset. The rewind is valid only when no more than DEPTH words have been written since that reset. In fall-through mode the first word is presented again one read-clock edge after the rewind edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Master reset, asynchronous, active low |
| prst_ni | input | 1 | Partial reset, asynchronous, active low |
| fwft_i | input | 1 | Timing-mode strap, sampled during master reset |
| wen_i | input | 1 | Write request (write clock) |
| din_i | input | 9 | Write data |
| ren_i | input | 1 | Read request (read clock) |
| rt_i | input | 1 | Retransmit pulse (read clock) |
| dout_o | output | 9 | Read data |
| rd_flag_o | output | 1 | Empty (standard) or output-valid (fall-through) |
| wr_flag_o | output | 1 | Full (standard) or input-ready (fall-through) |
| half_o | output | 1 | Storage array more than half full |

## Verification
The hardest situation to reach is the fall-through capacity boundary. The last accepted write only becomes possible after the first word has moved into the output register and the advanced read pointer has crossed back into the write domain. The stimulus therefore issues writes on every write-clock edge with reads held off, and counts acceptances over a window long enough for that crossing to settle. Retransmit is reached in both modes by partly draining a short burst, pulsing the rewind and replaying the whole burst. Random interleaved traffic, with writes attempted while full and reads attempted while empty, checks ordering across the clock crossing.

// File: rtl/dm_fifo_pkg.sv
package dm_fifo_pkg;
  localparam int unsigned DATA_W = 9;
  typedef enum logic {MODE_STD = 1'b0, MODE_FWFT = 1'b1} fifo_mode_e;
endpackage

// File: rtl/dm_fifo_sync.sv
module dm_fifo_sync #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/dm_fifo_mem.sv
module dm_fifo_mem #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 9
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned N = 1 << AW;
  logic [DW-1:0] mem_q [N];
  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dm_fifo_wr.sv
module dm_fifo_wr #(
  parameter int unsigned AW = 4
) (
  input  logic        wclk_i,
  input  logic        rst_ni,
  input  logic        wen_i,
  input  logic [AW:0] rgray_i,
  output logic        we_o,
  output logic [AW:0] wbin_o,
  output logic [AW:0] wgray_o,
  output logic        full_o,
  output logic        half_o
);
  localparam int unsigned PW = AW + 1;
  localparam logic [AW:0] HALF = PW'(1 << (AW - 1));

  logic [AW:0] wbin_q, wgray_q, rbin, fill;

  assign full_o = (wgray_q == {~rgray_i[AW:AW-1], rgray_i[AW-2:0]});
  assign we_o   = wen_i & ~full_o;

  always_comb begin
    for (int i = 0; i <= int'(AW); i++) rbin[i] = ^(rgray_i >> i);
  end

  assign fill   = wbin_q - rbin;
  assign half_o = fill > HALF;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (we_o) begin
      wbin_q  <= wbin_q + 1'b1;
      wgray_q <= (wbin_q + 1'b1) ^ ((wbin_q + 1'b1) >> 1);
    end
  end

  assign wbin_o  = wbin_q;
  assign wgray_o = wgray_q;
endmodule

// File: rtl/dm_fifo_rd.sv
module dm_fifo_rd
  import dm_fifo_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  fifo_mode_e        mode_i,
  input  logic              ren_i,
  input  logic              rt_i,
  input  logic [AW:0]       wgray_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [AW-1:0]     raddr_o,
  output logic [AW:0]       rbin_o,
  output logic [AW:0]       rgray_o,
  output logic              empty_o,
  output logic [DATA_W-1:0] dout_o,
  output logic              flag_o
);
  logic [AW:0]       rbin_q, rgray_q;
  logic [DATA_W-1:0] dout_q;
  logic              ovalid_q, pop;

  assign empty_o = (rgray_q == wgray_i);
  // fall-through: refill output register whenever it is free or being consumed
  assign pop = (mode_i == MODE_FWFT) ? (~empty_o & (~ovalid_q | ren_i))
                                     : (ren_i & ~empty_o);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q   <= '0;
      rgray_q  <= '0;
      dout_q   <= '0;
      ovalid_q <= 1'b0;
    end else if (rt_i) begin
      rbin_q   <= '0;
      rgray_q  <= '0;
      ovalid_q <= 1'b0;
    end else if (pop) begin
      rbin_q   <= rbin_q + 1'b1;
      rgray_q  <= (rbin_q + 1'b1) ^ ((rbin_q + 1'b1) >> 1);
      dout_q   <= rdata_i;
      ovalid_q <= 1'b1;
    end else if (ren_i) begin
      ovalid_q <= 1'b0;
    end
  end

  assign raddr_o = rbin_q[AW-1:0];
  assign rbin_o  = rbin_q;
  assign rgray_o = rgray_q;
  assign dout_o  = dout_q;
  assign flag_o  = (mode_i == MODE_FWFT) ? ovalid_q : empty_o;
endmodule

// File: rtl/dm_fifo.sv
module dm_fifo
  import dm_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              prst_ni,
  input  logic              fwft_i,
  input  logic              wen_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              ren_i,
  input  logic              rt_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              rd_flag_o,
  output logic              wr_flag_o,
  output logic              half_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic              ptr_rst_n;
  fifo_mode_e        wmode_q, rmode_q;
  logic              we, full_w, empty_r;
  logic [AW:0]       w_bin, w_gray, r_bin, r_gray, rgray_w, wgray_r;
  logic [AW-1:0]     raddr;
  logic [DATA_W-1:0] rdata;

  assign ptr_rst_n = rst_ni & prst_ni;

  // strap captured per domain while master reset is held; partial reset keeps it
  always_ff @(posedge wclk_i) if (!rst_ni) wmode_q <= fifo_mode_e'(fwft_i);
  always_ff @(posedge rclk_i) if (!rst_ni) rmode_q <= fifo_mode_e'(fwft_i);

  dm_fifo_sync #(.W(AW + 1)) u_sync_r2w (
    .clk_i(wclk_i), .rst_ni(ptr_rst_n), .d_i(r_gray), .q_o(rgray_w)
  );
  dm_fifo_sync #(.W(AW + 1)) u_sync_w2r (
    .clk_i(rclk_i), .rst_ni(ptr_rst_n), .d_i(w_gray), .q_o(wgray_r)
  );

  dm_fifo_wr #(.AW(AW)) u_wr (
    .wclk_i(wclk_i), .rst_ni(ptr_rst_n), .wen_i(wen_i), .rgray_i(rgray_w),
    .we_o(we), .wbin_o(w_bin), .wgray_o(w_gray), .full_o(full_w), .half_o(half_o)
  );

  dm_fifo_mem #(.AW(AW), .DW(DATA_W)) u_mem (
    .wclk_i(wclk_i), .we_i(we), .waddr_i(w_bin[AW-1:0]), .wdata_i(din_i),
    .raddr_i(raddr), .rdata_o(rdata)
  );

  dm_fifo_rd #(.AW(AW)) u_rd (
    .rclk_i(rclk_i), .rst_ni(ptr_rst_n), .mode_i(rmode_q), .ren_i(ren_i),
    .rt_i(rt_i), .wgray_i(wgray_r), .rdata_i(rdata), .raddr_o(raddr),
    .rbin_o(r_bin), .rgray_o(r_gray), .empty_o(empty_r), .dout_o(dout_o),
    .flag_o(rd_flag_o)
  );

  assign wr_flag_o = (wmode_q == MODE_FWFT) ? ~full_w : full_w;
endmodule

// File: rtl/dm_fifo_chk.sv
module dm_fifo_chk
  import dm_fifo_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_n,
  input  logic              wen_i,
  input  logic              ren_i,
  input  logic              rt_i,
  input  logic              full_w,
  input  logic              empty_r,
  input  logic [AW:0]       w_bin,
  input  logic [AW:0]       w_gray,
  input  logic [AW:0]       r_bin,
  input  fifo_mode_e        rmode,
  input  logic              rd_flag,
  input  logic [DATA_W-1:0] dout
);
  p_gray_step_r2: assert property (@(posedge wclk_i) disable iff (!rst_n)
    $countones(w_gray ^ $past(w_gray)) <= 1);

  p_no_overflow_r3: assert property (@(posedge wclk_i) disable iff (!rst_n)
    (wen_i && full_w) |=> $stable(w_bin));

  p_no_underflow_r3: assert property (@(posedge rclk_i) disable iff (!rst_n)
    (rmode == MODE_STD && ren_i && empty_r && !rt_i) |=> ($stable(r_bin) && $stable(dout)));

  p_fwft_hold_r4: assert property (@(posedge rclk_i) disable iff (!rst_n)
    (rmode == MODE_FWFT && rd_flag && !ren_i && !rt_i) |=> (rd_flag && $stable(dout)));

  p_rewind_r8: assert property (@(posedge rclk_i) disable iff (!rst_n)
    rt_i |=> (r_bin == '0));
endmodule

bind dm_fifo dm_fifo_chk #(.AW(AW)) u_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_n(ptr_rst_n), .wen_i(wen_i),
  .ren_i(ren_i), .rt_i(rt_i), .full_w(full_w), .empty_r(empty_r),
  .w_bin(w_bin), .w_gray(w_gray), .r_bin(r_bin), .rmode(rmode_q),
  .rd_flag(rd_flag_o), .dout(dout_o)
);

// File: tb/dm_fifo_test.sv
module dm_fifo_test;
  localparam int D = 16;

  logic       wclk_i = 1'b0, rclk_i = 1'b0;
  logic       rst_ni = 1'b0, prst_ni = 1'b1, fwft_i = 1'b0;
  logic       wen_i = 1'b0, ren_i = 1'b0, rt_i = 1'b0;
  logic [8:0] din_i = '0;
  logic [8:0] dout_o;
  logic       rd_flag_o, wr_flag_o, half_o;

  int n_chk = 0, n_fail = 0;
  bit fw = 1'b0;
  logic [8:0] q[$];
  logic [8:0] hist[$];

  dm_fifo #(.DEPTH(D)) uut (.*);

  always #5 wclk_i = ~wclk_i;
  initial begin #3; forever #5 rclk_i = ~rclk_i; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit can_write();
    return fw ? wr_flag_o : !wr_flag_o;
  endfunction

  function automatic bit has_data();
    return fw ? rd_flag_o : !rd_flag_o;
  endfunction

  task automatic settle(input int n);
    repeat (n) @(posedge rclk_i);
    #1;
  endtask

  task automatic master_reset(input bit mode);
    rst_ni = 1'b0; fwft_i = mode;
    repeat (3) @(posedge rclk_i);
    repeat (3) @(posedge wclk_i);
    #1 rst_ni = 1'b1; fwft_i = ~mode;
    fw = mode; q.delete(); hist.delete();
    @(posedge wclk_i); #1;
  endtask

  task automatic wr_cycle(input bit want, input logic [8:0] d);
    wen_i = want; din_i = d;
    if (want && can_write()) begin q.push_back(d); hist.push_back(d); end
    @(posedge wclk_i); #1;
    wen_i = 1'b0;
  endtask

  task automatic rd_cycle(input bit want, input string req);
    bit pend;
    logic [8:0] e;
    ren_i = want;
    pend = want && has_data();
    if (pend && fw) begin
      e = q.pop_front();
      chk(dout_o == e, req, dout_o, e);
    end
    @(posedge rclk_i); #1;
    ren_i = 1'b0;
    if (pend && !fw) begin
      e = q.pop_front();
      chk(dout_o == e, req, dout_o, e);
    end
  endtask

  task automatic drain(input string req);
    for (int g = 0; g < 4 * D + 20 && q.size() > 0; g++) rd_cycle(1'b1, req);
    chk(q.size() == 0, req, q.size(), 0);
  endtask

  task automatic random_phase(input int nw);
    fork
      begin
        for (int i = 0; i < nw; i++) wr_cycle($urandom_range(0, 2) != 0, 9'($urandom));
      end
      begin
        for (int i = 0; i < nw + 200 && (i < nw || q.size() > 0); i++)
          rd_cycle($urandom_range(0, 1) == 1, "R2");
      end
    join
    settle(8);
    drain("R2");
  endtask

  task automatic capacity(input int exp, input string req);
    int acc = 0;
    for (int i = 0; i < 3 * D + 10; i++) begin
      if (can_write()) acc++;
      wr_cycle(1'b1, 9'(i));
    end
    chk(acc == exp, req, acc, exp);
  endtask

  task automatic rewind_test(input bit mode);
    master_reset(mode);
    for (int i = 0; i < 5; i++) wr_cycle(1'b1, 9'(9'h100 + i));
    settle(6);
    for (int i = 0; i < 3; i++) rd_cycle(1'b1, "R8");
    rt_i = 1'b1;
    @(posedge rclk_i); #1;
    rt_i = 1'b0;
    q = hist;
    if (mode) begin
      @(posedge rclk_i); #1;
      chk(rd_flag_o == 1'b1, "R8", rd_flag_o, 1);
    end
    for (int i = 0; i < 5; i++) rd_cycle(1'b1, "R8");
    chk(q.size() == 0, "R8", q.size(), 0);
  endtask

  initial begin
    $urandom(7);
    master_reset(1'b0);
    chk(rd_flag_o == 1'b1, "R1", rd_flag_o, 1);
    chk(wr_flag_o == 1'b0, "R1", wr_flag_o, 0);
    chk(dout_o == 9'd0, "R7", dout_o, 0);
    chk(half_o == 1'b0, "R6", half_o, 0);

    // R3: reads on an empty buffer leave the output alone
    for (int i = 0; i < 3; i++) rd_cycle(1'b1, "R3");
    chk(dout_o == 9'd0, "R3", dout_o, 0);
    wr_cycle(1'b1, 9'h0a5);
    settle(4);
    rd_cycle(1'b1, "R3");

    // R6 threshold sweep, standard mode
    master_reset(1'b0);
    for (int k = 1; k <= D; k++) begin
      wr_cycle(1'b1, 9'(k));
      settle(4);
      chk(half_o == (k > D / 2), "R6", half_o, k > D / 2);
    end
    chk(wr_flag_o == 1'b1, "R1", wr_flag_o, 1);
    wr_cycle(1'b1, 9'h1ff);   // R3: dropped while full
    settle(4);
    for (int i = 0; i < D / 2; i++) rd_cycle(1'b1, "R2");
    repeat (4) @(posedge wclk_i); #1;
    chk(half_o == 1'b0, "R6", half_o, 0);
    drain("R3");

    master_reset(1'b0);
    capacity(D, "R5");
    settle(6);
    drain("R5");

    master_reset(1'b1);
    chk(rd_flag_o == 1'b0, "R1", rd_flag_o, 0);
    chk(wr_flag_o == 1'b1, "R1", wr_flag_o, 1);
    capacity(D + 1, "R5");
    chk(wr_flag_o == 1'b0, "R1", wr_flag_o, 0);
    settle(6);
    drain("R5");

    // R4 first-word latency in fall-through mode
    master_reset(1'b1);
    settle(4);
    @(posedge wclk_i); #1;
    wr_cycle(1'b1, 9'h13c);
    @(posedge rclk_i); @(posedge rclk_i); #1;
    chk(rd_flag_o == 1'b0, "R4", rd_flag_o, 0);
    @(posedge rclk_i); #1;
    chk(rd_flag_o == 1'b1, "R4", rd_flag_o, 1);
    chk(dout_o == 9'h13c, "R4", dout_o, 9'h13c);
    settle(5);
    chk(dout_o == 9'h13c && rd_flag_o, "R4", dout_o, 9'h13c);
    drain("R4");

    // R7 partial reset keeps fall-through mode
    for (int i = 0; i < 3; i++) wr_cycle(1'b1, 9'(9'h40 + i));
    settle(6);
    prst_ni = 1'b0; fwft_i = 1'b0;
    settle(2);
    prst_ni = 1'b1; q.delete(); hist.delete();
    settle(1);
    chk(rd_flag_o == 1'b0, "R7", rd_flag_o, 0);
    chk(dout_o == 9'd0, "R7", dout_o, 0);
    @(posedge wclk_i); #1;
    wr_cycle(1'b1, 9'h055);
    settle(6);
    chk(rd_flag_o == 1'b1, "R7", rd_flag_o, 1);
    chk(dout_o == 9'h055, "R7", dout_o, 9'h055);

    // R7 master reset reloads standard mode
    master_reset(1'b0);
    wr_cycle(1'b1, 9'h066);
    settle(6);
    chk(rd_flag_o == 1'b0, "R7", rd_flag_o, 0);
    chk(dout_o == 9'd0, "R7", dout_o, 0);
    rd_cycle(1'b1, "R7");

    rewind_test(1'b0);
    rewind_test(1'b1);

    master_reset(1'b0);
    random_phase(400);
    master_reset(1'b1);
    random_phase(400);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule